// File: doc/BRIEF.md
# Receive FIFO Congestion PAUSE Trigger

This block tracks how many bytes sit in a receive buffer FIFO and decides when the transmit MAC has to emit IEEE 802.3x PAUSE frames. The occupancy count rises with the write-side byte count and falls with the read-side byte count. It also falls when a frame is thrown away because no host buffer is free. Two programmable thresholds give hysteresis. Occupancy above the upper one starts a congestion episode. Occupancy below the lower one ends it. Anything in between keeps the current state.

An episode starts with one PAUSE request carrying the programmed initial quanta. While the episode lasts, a refresh timer re-issues that request. The timer counts in pause quanta of 512 bit times. When the episode ends, a zero-quanta request is issued on its own. Requests use a request/acknowledge handshake with a 16-bit quanta value. A pending request is never queued behind another: a newer event overwrites it.

The block also applies the per-ring admission policy to the frame at the head of the FIFO when that frame's ring has no free host buffer. In lossy mode the frame is discarded and its bytes are released. In lossless mode the frame is held. A receive-side "ignore incoming PAUSE" control bit is passed straight through to the MAC.

Top module: `pause_trigger`

## Requirements
- R1: `occ_level` becomes occupancy + `wr_bytes` − `rd_bytes` − (released frame bytes) one clock after the counts are presented. The result is clamped at 0 and at `FIFO_BYTES`, and it holds when nothing moves.
- R2: With `fc_tx_en` high, occupancy strictly above `thr_on` starts congestion and raises `pause_req` with `pause_quanta` = `quanta_init`. Occupancy equal to `thr_on` does not.
- R3: Once congested, the block stays congested, with no new request, while occupancy is greater than or equal to `thr_off`.
- R4: When occupancy falls strictly below `thr_off` during congestion, exactly one request with `pause_quanta` = 0 is raised. After it, no further request appears while occupancy stays low.
- R5: While congestion lasts, a refresh request carrying `quanta_init` is raised exactly `quanta_refresh` × 512 / `BITS_PER_CYCLE` clock edges after the edge that samples the acknowledge of a non-zero request. A `quanta_refresh` of 0 disables refresh.
- R6: `pause_req` stays high with a stable `pause_quanta` until `pause_ack` is sampled high. A newer event arriving before the acknowledge replaces the pending quanta. For example, an exit turns a pending 0xFFFF into 0.
- R7: While `fc_tx_en` is low, `pause_req` is never raised, whatever the occupancy.
- R8: The head frame is judged by its ring's bits `ring_lossless[head_ring]` and `ring_buf_free[head_ring]`. If `head_valid` is high, no buffer is free, and the ring's lossless bit is 0, `head_drop` is high in the same cycle and `head_len` bytes leave the occupancy at the next edge. If the lossless bit is 1, `head_stall` is high and the occupancy keeps those bytes. If a buffer is free, both outputs are low.
- R9: `pause_rx_ignore` equals `pause_rx_ignore_cfg` combinationally.
- R10: After synchronous active-low reset, `occ_level` is 0 and `pause_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_tx_en | input | 1 | Transmit flow control enable |
| pause_rx_ignore_cfg | input | 1 | Setting: ignore incoming PAUSE frames |
| thr_on | input | OCC_W | Congestion entry threshold in bytes |
| thr_off | input | OCC_W | Congestion exit threshold in bytes |
| quanta_init | input | 16 | Quanta sent on entry and on refresh |
| quanta_refresh | input | 16 | Refresh period in pause quanta |
| wr_bytes | input | CNT_W | Bytes written into the FIFO this cycle |
| rd_bytes | input | CNT_W | Bytes read out of the FIFO this cycle |
| head_valid | input | 1 | A frame at the FIFO head awaits a host buffer |
| head_ring | input | RING_W | Ring index of the head frame |
| head_len | input | OCC_W | Byte length of the head frame |
| ring_lossless | input | NUM_RINGS | Per-ring mode, 1 = lossless, 0 = lossy |
| ring_buf_free | input | NUM_RINGS | Per-ring free host buffer flag |
| pause_ack | input | 1 | Transmit MAC accepts the pending request |
| occ_level | output | OCC_W | Current FIFO occupancy in bytes |
| head_drop | output | 1 | Head frame discarded this cycle |
| head_stall | output | 1 | Head frame held in the FIFO this cycle |
| pause_req | output | 1 | PAUSE frame request |
| pause_quanta | output | 16 | Quanta for the requested frame |
| pause_rx_ignore | output | 1 | Pass-through of the ignore setting |

## Verification
The in-RTL assertions check on every cycle:
- the occupancy bound, the idle hold and the lossless hold;
- the hysteresis entry and hold rules;
- request stability until acknowledge;
- silence while flow control is off;
- timer silence after an exit.

Only the bench scenarios can show what depends on an exact sequence:
- the order and values of the requests (entry, refresh, zero-quanta exit);
- the exact refresh distance in cycles;
- the overwrite of an unacknowledged request;
- the per-ring drop and hold outcome at the ports.

// File: rtl/pause_trig_pkg.sv
// Shared types for the PAUSE trigger: the kind of event that loads a request.
package pause_trig_pkg;
    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_ENTER   = 2'd1,
        EV_REFRESH = 2'd2,
        EV_EXIT    = 2'd3
    } pause_ev_e;
endpackage

// File: rtl/pause_trig_fill.sv
// Byte occupancy counter with per-ring admission for the FIFO head frame.
// Assumes the write and read counts of one cycle are presented together.
// A lossy drop releases head_len bytes in the same update.
module pause_trig_fill #(
    parameter int FIFO_BYTES = 4096,
    parameter int CNT_W      = 8,
    parameter int NUM_RINGS  = 4,
    localparam int OCC_W     = $clog2(FIFO_BYTES + 1),
    localparam int RING_W    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     wr_bytes,
    input  logic [CNT_W-1:0]     rd_bytes,
    input  logic                 head_valid,
    input  logic [RING_W-1:0]    head_ring,
    input  logic [OCC_W-1:0]     head_len,
    input  logic [NUM_RINGS-1:0] ring_lossless,
    input  logic [NUM_RINGS-1:0] ring_buf_free,
    output logic [OCC_W-1:0]     occ,
    output logic                 drop,
    output logic                 stall
);
    localparam int SW = OCC_W + 2;

    logic [OCC_W-1:0] occ_q;
    logic [SW-1:0]    up_sum, dn_sum, occ_nxt;
    logic             ring_ll, ring_free;

    // Look up the head frame's ring policy and buffer availability.
    assign ring_ll   = ring_lossless[head_ring];
    assign ring_free = ring_buf_free[head_ring];
    assign drop      = head_valid && !ring_free && !ring_ll;
    assign stall     = head_valid && !ring_free && ring_ll;

    // Next occupancy, clamped to the range [0, FIFO_BYTES].
    always_comb begin
        up_sum = SW'(occ_q) + SW'(wr_bytes);
        dn_sum = SW'(rd_bytes) + (drop ? SW'(head_len) : '0);
        if (dn_sum >= up_sum)
            occ_nxt = '0;
        else if ((up_sum - dn_sum) > SW'(FIFO_BYTES))
            occ_nxt = SW'(FIFO_BYTES);
        else
            occ_nxt = up_sum - dn_sum;
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_nxt[OCC_W-1:0];
    end

    assign occ = occ_q;

    // R1: occupancy never exceeds capacity
    a_r1_cap: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(FIFO_BYTES));
    // R1: no traffic leaves the count unchanged
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bytes == '0 && rd_bytes == '0 && !drop) |=> $stable(occ_q));
    // R8: a held frame releases no bytes
    a_r8_stall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && rd_bytes == '0) |=> occ_q >= $past(occ_q));
endmodule

// File: rtl/pause_trig_congest.sv
// Hysteresis congestion detector and request event selector.
// Assumes thr_off <= thr_on. Exit outranks entry, and entry outranks refresh.
module pause_trig_congest
    import pause_trig_pkg::*;
#(
    parameter int OCC_W = 13,
    parameter int QW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fc_en,
    input  logic [OCC_W-1:0] occ,
    input  logic [OCC_W-1:0] thr_on,
    input  logic [OCC_W-1:0] thr_off,
    input  logic [QW-1:0]    quanta_init,
    input  logic             expire,
    output logic             congested,
    output pause_ev_e        ev,
    output logic [QW-1:0]    ev_quanta
);
    logic cong_q, cong_n;

    // Next congestion state with hysteresis; forced off when flow control is off.
    always_comb begin
        if (!fc_en)      cong_n = 1'b0;
        else if (cong_q) cong_n = !(occ < thr_off);
        else             cong_n = (occ > thr_on);
    end

    // Pick the event that loads the request holder this cycle.
    always_comb begin
        ev        = EV_NONE;
        ev_quanta = quanta_init;
        if (cong_q && !cong_n && fc_en) begin
            ev        = EV_EXIT;
            ev_quanta = '0;
        end else if (cong_n && !cong_q) begin
            ev = EV_ENTER;
        end else if (cong_n && cong_q && expire) begin
            ev = EV_REFRESH;
        end
    end

    // Congestion state register.
    always_ff @(posedge clk) begin
        if (!rst_n) cong_q <= 1'b0;
        else        cong_q <= cong_n;
    end

    assign congested = cong_q;

    // R2: occupancy above the on threshold starts congestion
    a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && occ > thr_on) |=> congested);
    // R3: occupancy at or above the off threshold keeps congestion
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (congested && fc_en && occ >= thr_off) |=> congested);
endmodule

// File: rtl/pause_trig_timer.sv
// Refresh timer counting pause quanta of 512 bit times.
// A prescaler (present only when PRESC > 1) turns clock cycles into quanta ticks.
// Assumes restart is a single-cycle pulse and stop outranks restart.
module pause_trig_timer #(
    parameter int QW    = 16,
    parameter int PRESC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          stop,
    input  logic [QW-1:0] period,
    output logic          expire
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

    logic          run_q;
    logic [QW-1:0] cnt_q;
    logic          tick;

    generate
        if (PRESC > 1) begin : g_presc
            logic [PW-1:0] presc_q;
            // Prescaler: cleared on restart and while idle, wraps every PRESC cycles.
            always_ff @(posedge clk) begin
                if (!rst_n || stop || restart || !run_q) presc_q <= '0;
                else if (presc_q == PW'(PRESC - 1))      presc_q <= '0;
                else                                     presc_q <= presc_q + 1'b1;
            end
            assign tick = run_q && (presc_q == PW'(PRESC - 1));
        end else begin : g_noprescale
            assign tick = run_q;
        end
    endgenerate

    assign expire = tick && (cnt_q == period - 1'b1);

    // Run flag and quanta counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (stop) begin
            run_q <= 1'b0;
        end else if (restart) begin
            run_q <= (period != '0);
            cnt_q <= '0;
        end else if (expire) begin
            run_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: a stopped timer does not fire on the next cycle
    a_r4_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !expire);
endmodule

// File: rtl/pause_trig_hold.sv
// Single-entry request holder for the transmit MAC handshake.
// A new event overwrites the pending quanta, so requests never queue.
// The request is cleared when flow control is turned off.
module pause_trig_hold #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fc_en,
    input  logic          ev_valid,
    input  logic [QW-1:0] ev_quanta,
    input  logic          ack,
    output logic          req,
    output logic [QW-1:0] quanta
);
    logic          pend_q;
    logic [QW-1:0] quanta_q;

    // Load on event, clear on acknowledge, flush when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            quanta_q <= '0;
        end else if (!fc_en) begin
            pend_q <= 1'b0;
        end else if (ev_valid) begin
            pend_q   <= 1'b1;
            quanta_q <= ev_quanta;
        end else if (ack && pend_q) begin
            pend_q <= 1'b0;
        end
    end

    assign req    = pend_q;
    assign quanta = quanta_q;

    // R6: an unacknowledged request holds its quanta
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !ev_valid && fc_en) |=> (req && $stable(quanta)));
    // R7: no request while flow control is off
    a_r7_fc_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |=> !req);
endmodule

// File: rtl/pause_trigger.sv
// Top of the FIFO congestion PAUSE trigger.
// Joins the occupancy counter, the hysteresis detector, the refresh timer and
// the request holder. Assumes the register inputs change only between episodes.
module pause_trigger
    import pause_trig_pkg::*;
#(
    parameter int FIFO_BYTES     = 4096,
    parameter int CNT_W          = 8,
    parameter int NUM_RINGS      = 4,
    parameter int BITS_PER_CYCLE = 8,
    parameter int QW             = 16,
    localparam int OCC_W         = $clog2(FIFO_BYTES + 1),
    localparam int RING_W        = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1,
    localparam int PRESC         = (512 / BITS_PER_CYCLE > 0) ? 512 / BITS_PER_CYCLE : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fc_tx_en,
    input  logic                 pause_rx_ignore_cfg,
    input  logic [OCC_W-1:0]     thr_on,
    input  logic [OCC_W-1:0]     thr_off,
    input  logic [QW-1:0]        quanta_init,
    input  logic [QW-1:0]        quanta_refresh,
    input  logic [CNT_W-1:0]     wr_bytes,
    input  logic [CNT_W-1:0]     rd_bytes,
    input  logic                 head_valid,
    input  logic [RING_W-1:0]    head_ring,
    input  logic [OCC_W-1:0]     head_len,
    input  logic [NUM_RINGS-1:0] ring_lossless,
    input  logic [NUM_RINGS-1:0] ring_buf_free,
    input  logic                 pause_ack,
    output logic [OCC_W-1:0]     occ_level,
    output logic                 head_drop,
    output logic                 head_stall,
    output logic                 pause_req,
    output logic [QW-1:0]        pause_quanta,
    output logic                 pause_rx_ignore
);
    logic          congested;
    logic          expire;
    logic          ack_fire;
    logic          t_restart, t_stop;
    pause_ev_e     ev;
    logic [QW-1:0] ev_quanta;

    pause_trig_fill #(
        .FIFO_BYTES (FIFO_BYTES),
        .CNT_W      (CNT_W),
        .NUM_RINGS  (NUM_RINGS)
    ) u_fill (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_bytes      (wr_bytes),
        .rd_bytes      (rd_bytes),
        .head_valid    (head_valid),
        .head_ring     (head_ring),
        .head_len      (head_len),
        .ring_lossless (ring_lossless),
        .ring_buf_free (ring_buf_free),
        .occ           (occ_level),
        .drop          (head_drop),
        .stall         (head_stall)
    );

    pause_trig_congest #(
        .OCC_W (OCC_W),
        .QW    (QW)
    ) u_congest (
        .clk         (clk),
        .rst_n       (rst_n),
        .fc_en       (fc_tx_en),
        .occ         (occ_level),
        .thr_on      (thr_on),
        .thr_off     (thr_off),
        .quanta_init (quanta_init),
        .expire      (expire),
        .congested   (congested),
        .ev          (ev),
        .ev_quanta   (ev_quanta)
    );

    // Restart the timer on acknowledge of a non-zero request; stop it on exit or disable.
    assign ack_fire  = pause_req && pause_ack;
    assign t_restart = ack_fire && (pause_quanta != '0) && congested;
    assign t_stop    = (ev == EV_EXIT) || !fc_tx_en;

    pause_trig_timer #(
        .QW    (QW),
        .PRESC (PRESC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (t_restart),
        .stop    (t_stop),
        .period  (quanta_refresh),
        .expire  (expire)
    );

    pause_trig_hold #(
        .QW (QW)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .fc_en     (fc_tx_en),
        .ev_valid  (ev != EV_NONE),
        .ev_quanta (ev_quanta),
        .ack       (pause_ack),
        .req       (pause_req),
        .quanta    (pause_quanta)
    );

    // R9: receive-side ignore setting passes straight through.
    assign pause_rx_ignore = pause_rx_ignore_cfg;
endmodule

// File: tb/pause_trigger_tb.sv
// Scoreboard bench: scenarios push the expected PAUSE quanta, and a MAC model
// pops and compares each request it acknowledges.
module pause_trigger_tb;
    localparam int FIFO_BYTES = 4096;
    localparam int OCC_W      = $clog2(FIFO_BYTES + 1);
    localparam int REFRESH_Q  = 2;
    localparam int REFRESH_CY = REFRESH_Q * 512 / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fc_tx_en = 1'b0;
    logic        ign_cfg = 1'b0;
    logic [OCC_W-1:0] thr_on = OCC_W'(300);
    logic [OCC_W-1:0] thr_off = OCC_W'(100);
    logic [15:0] q_init = 16'hFFFF;
    logic [15:0] q_ref = 16'(REFRESH_Q);
    logic [7:0]  wr_bytes = '0, rd_bytes = '0;
    logic        head_valid = 1'b0;
    logic [1:0]  head_ring = '0;
    logic [OCC_W-1:0] head_len = '0;
    logic [3:0]  ring_ll = 4'b0010;
    logic [3:0]  ring_free = 4'b1111;
    logic        pause_ack = 1'b0;
    logic [OCC_W-1:0] occ_level;
    logic        head_drop, head_stall, pause_req, pause_rx_ignore;
    logic [15:0] pause_quanta;

    int checks = 0, fails = 0, cyc = 0;
    int last_req_cyc = 0, last_ack_edge = 0;
    bit ack_en = 1'b1;
    logic [15:0] exp_q[$];

    pause_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .fc_tx_en(fc_tx_en),
        .pause_rx_ignore_cfg(ign_cfg), .thr_on(thr_on), .thr_off(thr_off),
        .quanta_init(q_init), .quanta_refresh(q_ref),
        .wr_bytes(wr_bytes), .rd_bytes(rd_bytes),
        .head_valid(head_valid), .head_ring(head_ring), .head_len(head_len),
        .ring_lossless(ring_ll), .ring_buf_free(ring_free),
        .pause_ack(pause_ack), .occ_level(occ_level),
        .head_drop(head_drop), .head_stall(head_stall),
        .pause_req(pause_req), .pause_quanta(pause_quanta),
        .pause_rx_ignore(pause_rx_ignore)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Present one cycle of byte counts, starting and ending on a falling edge.
    task automatic drive(input int w, input int r);
        wr_bytes = 8'(w);
        rd_bytes = 8'(r);
        @(negedge clk);
        wr_bytes = '0;
        rd_bytes = '0;
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // MAC model and scoreboard monitor: compare the quanta, then acknowledge for one cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (pause_ack) begin
                pause_ack = 1'b0;
            end else if (rst_n && pause_req && ack_en) begin
                last_req_cyc = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected request", int'(pause_quanta), -1);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(pause_quanta == e, "R6 scoreboard quanta", int'(pause_quanta), int'(e));
                end
                pause_ack = 1'b1;
                last_ack_edge = cyc + 1;
            end
        end
    end

    initial begin
        int a_e, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(occ_level == 0, "R10 reset occupancy", int'(occ_level), 0);
        chk(pause_req == 1'b0, "R10 reset request", int'(pause_req), 0);

        // R9 pass-through of the ignore setting
        ign_cfg = 1'b1; #1;
        chk(pause_rx_ignore == 1'b1, "R9 ignore high", int'(pause_rx_ignore), 1);
        ign_cfg = 1'b0; #1;
        chk(pause_rx_ignore == 1'b0, "R9 ignore low", int'(pause_rx_ignore), 0);
        @(negedge clk);

        // R1 occupancy arithmetic and clamping (flow control off, R7)
        drive(100, 0);
        chk(occ_level == 100, "R1 write", int'(occ_level), 100);
        drive(50, 30);
        chk(occ_level == 120, "R1 write and read", int'(occ_level), 120);
        drive(0, 200);
        chk(occ_level == 0, "R1 clamp at zero", int'(occ_level), 0);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            drive(255, 0);
            if (pause_req) n++;
        end
        chk(occ_level == FIFO_BYTES, "R1 clamp at capacity", int'(occ_level), FIFO_BYTES);
        repeat (20) begin
            @(negedge clk);
            if (pause_req) n++;
        end
        chk(n == 0, "R7 no request with flow control off", n, 0);
        for (int i = 0; i < 20; i++) drive(0, 255);
        chk(occ_level == 0, "R1 drain", int'(occ_level), 0);

        // R2 entry only strictly above the on threshold
        fc_tx_en = 1'b1;
        drive(255, 0);
        drive(45, 0);
        repeat (5) @(negedge clk);
        chk(pause_req == 1'b0, "R2 no entry at threshold", int'(pause_req), 0);
        exp_q.push_back(16'hFFFF);
        drive(1, 0);
        wait_empty();
        a_e = last_ack_edge;

        // R5 refresh distance after acknowledge
        exp_q.push_back(16'hFFFF);
        wait_empty();
        chk(last_req_cyc - a_e == REFRESH_CY, "R5 refresh distance",
            last_req_cyc - a_e, REFRESH_CY);

        // R3 hysteresis: occupancy at the off threshold keeps congestion
        drive(0, 201);
        chk(occ_level == 100, "R3 occupancy at off threshold", int'(occ_level), 100);
        n = 0;
        repeat (10) begin
            @(negedge clk);
            if (pause_req) n++;
        end
        chk(n == 0, "R3 no exit at off threshold", n, 0);

        // R4 exit sends zero quanta, then silence
        exp_q.push_back(16'h0000);
        drive(0, 1);
        wait_empty();
        n = 0;
        repeat (300) begin
            @(negedge clk);
            if (pause_req) n++;
        end
        chk(n == 0, "R4 no request after exit", n, 0);

        // R6 hold without acknowledge, then replacement by exit
        ack_en = 1'b0;
        drive(0, 255);
        drive(255, 0);
        drive(46, 0);
        repeat (4) @(negedge clk);
        chk(pause_req && pause_quanta == 16'hFFFF, "R2 entry quanta",
            int'(pause_quanta), 16'hFFFF);
        repeat (20) @(negedge clk);
        chk(pause_req && pause_quanta == 16'hFFFF, "R6 held until acknowledge",
            int'(pause_quanta), 16'hFFFF);
        drive(0, 255);
        repeat (3) @(negedge clk);
        chk(pause_req && pause_quanta == 16'h0000, "R6 replaced by exit",
            int'(pause_quanta), 0);
        exp_q.push_back(16'h0000);
        ack_en = 1'b1;
        wait_empty();
        repeat (5) @(negedge clk);
        chk(pause_req == 1'b0, "R6 cleared after acknowledge", int'(pause_req), 0);

        // R8 lossy drop releases bytes; lossless ring holds them
        drive(200, 0);
        chk(occ_level == 246, "R8 setup occupancy", int'(occ_level), 246);
        ring_free = 4'b1100;
        head_valid = 1'b1; head_ring = 2'd0; head_len = OCC_W'(80); #1;
        chk(head_drop && !head_stall, "R8 lossy drop", int'(head_drop), 1);
        @(negedge clk);
        head_valid = 1'b0;
        chk(occ_level == 166, "R8 drop releases bytes", int'(occ_level), 166);
        head_valid = 1'b1; head_ring = 2'd1; #1;
        chk(head_stall && !head_drop, "R8 lossless stall", int'(head_stall), 1);
        @(negedge clk);
        head_valid = 1'b0;
        chk(occ_level == 166, "R8 stall keeps bytes", int'(occ_level), 166);
        ring_free = 4'b1111;
        head_valid = 1'b1; #1;
        chk(!head_stall && !head_drop, "R8 buffer free", int'(head_stall | head_drop), 0);
        @(negedge clk);
        head_valid = 1'b0;
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule